// File: doc/BRIEF.md
# Next-PC Prediction Fetch Unit

This block owns the program counter of a pipelined processor's fetch stage. In every cycle it guesses the address that follows the instruction being fetched. The guess comes from a direct-mapped table looked up with the fetch PC alone; the instruction is not decoded. The guess is offered as `pred_next_o`, and the pipeline carries it alongside the instruction.

A later resolve stage hands back the instruction's PC, the prediction that travelled with it, and the branch and jump outcomes. The block derives the correct next PC from these. It raises `mispredict_o` when that address differs from the carried prediction, and it steers fetch to the correct address. When an instruction retires, its PC and true successor are written into the table. The table remembers successor addresses rather than taken/not-taken bits, so a later fetch of the same PC predicts the same target.

The PC register takes its next value from one of four named update sources, in priority order:
- **BOOT**: reset, which loads the start address.
- **REDIRECT**: a mispredict, which loads the correct next PC.
- **PREDICT**: fetch is not stalled, so the predicted next PC is loaded.
- **HOLD**: fetch is stalled, so the PC keeps its value.

Top module: `npc_fetch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_pc_o` is loaded with `START_PC`, which is 32'h0000_1000 by default. Every table entry becomes invalid, so any entry trained before the reset no longer affects `pred_next_o`.
- R2: When the table entry selected by the fetch PC is invalid, `pred_next_o` equals `fetch_pc_o + 4`.
- R3: The table entry is selected by `fetch_pc_o[11:2]` (1024 entries). The table has no tag, so two PCs that differ only above bit 11 share an entry. When that entry is valid, `pred_next_o` is its stored address.
- R4: The correct next PC is chosen in this priority order:
  - `res_br_target_i` when `res_br_taken_i` is 1;
  - otherwise `res_jump_target_i` when `res_is_jump_i` is 1;
  - otherwise `res_pc_i + 4`.
- R5: `mispredict_o` is 1 exactly when `res_bubble_i` is 0 and the correct next PC differs from `res_pred_i`. It is combinational, in the same cycle as the resolve inputs.
- R6: At each clock edge the PC is updated from the highest-priority source that applies: reset (BOOT), then mispredict (REDIRECT, loading the correct next PC), then not stalled (PREDICT, loading `pred_next_o`). If none applies, the PC holds (HOLD). A stall does not block a redirect.
- R7: When `ret_valid_i` is 1 at a clock edge, the entry selected by `ret_pc_i[11:2]` stores `ret_next_i` and becomes valid. This write also happens when `ret_next_i` equals `ret_pc_i + 4`, so a formerly taken entry can be retrained to fall-through.
- R8: When a write and a lookup select the same entry in the same cycle, `pred_next_o` shows the old contents in that cycle and the new contents from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Fetch stall; the PC holds unless a redirect occurs |
| res_bubble_i | input | 1 | Resolve-stage slot holds a bubble or no-op |
| res_pc_i | input | 32 | PC of the resolving instruction |
| res_pred_i | input | 32 | Prediction that travelled with the resolving instruction |
| res_br_taken_i | input | 1 | Resolving instruction is a taken branch |
| res_br_target_i | input | 32 | Branch target |
| res_is_jump_i | input | 1 | Resolving instruction is a jump |
| res_jump_target_i | input | 32 | Jump target |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| ret_pc_i | input | 32 | PC of the retiring instruction |
| ret_next_i | input | 32 | True next PC of the retiring instruction |
| fetch_pc_o | output | 32 | Current fetch PC |
| pred_next_o | output | 32 | Predicted next fetch PC |
| mispredict_o | output | 1 | Resolve-stage prediction was wrong |

## Verification
Several directed patterns each isolate one behaviour:
- Pure sequential fetch with an empty table separates the plus-4 default from table hits.
- Resolve patterns with both a branch and a jump active show which target wins.
- A bubble carrying a wrong prediction shows that the mispredict flag is gated off.
- Training one PC and then fetching its alias 4 KiB away shows the tagless index.
- A same-entry write during a stalled fetch shows whether the lookup sees old or new contents.

Seeded random traffic then mixes stalls, redirects, bubbles and retire writes over a small, heavily aliased address range. This stresses the PC update priority against a table model kept in the bench.

// File: rtl/npc_fetch_pkg.sv
package npc_fetch_pkg;

    // Source of the next PC register value, in priority order
    typedef enum logic [1:0] {
        PCSRC_BOOT     = 2'd0,
        PCSRC_REDIRECT = 2'd1,
        PCSRC_PREDICT  = 2'd2,
        PCSRC_HOLD     = 2'd3
    } pc_src_e;

endpackage

// File: rtl/npc_table.sv
module npc_table #(
    parameter int XLEN       = 32,
    parameter int IDX_BITS   = 10,
    parameter int INST_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] rd_pc,
    output logic [XLEN-1:0] rd_next,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_pc,
    input  logic [XLEN-1:0] wr_next
);
    localparam int DEPTH  = 1 << IDX_BITS;
    localparam int IDX_LO = $clog2(INST_BYTES);
    localparam int IDX_HI = IDX_LO + IDX_BITS - 1;

    logic [XLEN-1:0]     slot_q [DEPTH];
    logic [DEPTH-1:0]    live_q;
    logic [IDX_BITS-1:0] rd_idx;
    logic [IDX_BITS-1:0] wr_idx;
    logic                unused_wr_bits;

    assign rd_idx = rd_pc[IDX_HI:IDX_LO];
    assign wr_idx = wr_pc[IDX_HI:IDX_LO];
    assign unused_wr_bits = ^{wr_pc[XLEN-1:IDX_HI+1], wr_pc[IDX_LO-1:0]};

    // Storage: written at the edge, so a same-cycle lookup sees old data
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_idx] <= wr_next;
        end
    end

    // Per-entry valid bits, cleared by reset
    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
        end else if (wr_en) begin
            live_q[wr_idx] <= 1'b1;
        end
    end

    // Untagged lookup; invalid entries fall back to the sequential address
    always_comb begin
        if (live_q[rd_idx]) begin
            rd_next = slot_q[rd_idx];
        end else begin
            rd_next = rd_pc + XLEN'(INST_BYTES);
        end
    end

endmodule

// File: rtl/npc_resolve.sv
module npc_resolve #(
    parameter int XLEN       = 32,
    parameter int INST_BYTES = 4
) (
    input  logic            bubble,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] carried_pred,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_target,
    input  logic            is_jump,
    input  logic [XLEN-1:0] jump_target,
    output logic [XLEN-1:0] good_next,
    output logic            wrong
);
    // Branch outcome outranks jump, which outranks fall-through
    always_comb begin
        if (br_taken) begin
            good_next = br_target;
        end else if (is_jump) begin
            good_next = jump_target;
        end else begin
            good_next = pc + XLEN'(INST_BYTES);
        end
        wrong = !bubble && (good_next != carried_pred);
    end

endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg
    import npc_fetch_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] START_PC = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic            redirect,
    input  logic [XLEN-1:0] redirect_pc,
    input  logic [XLEN-1:0] predict_pc,
    output logic [XLEN-1:0] pc_q
);
    pc_src_e src;

    // Source selection by fixed priority
    always_comb begin
        if (rst) begin
            src = PCSRC_BOOT;
        end else if (redirect) begin
            src = PCSRC_REDIRECT;
        end else if (!stall) begin
            src = PCSRC_PREDICT;
        end else begin
            src = PCSRC_HOLD;
        end
    end

    // PC register
    always_ff @(posedge clk) begin
        unique case (src)
            PCSRC_BOOT:     pc_q <= START_PC;
            PCSRC_REDIRECT: pc_q <= redirect_pc;
            PCSRC_PREDICT:  pc_q <= predict_pc;
            PCSRC_HOLD:     pc_q <= pc_q;
            default:        pc_q <= START_PC;
        endcase
    end

endmodule

// File: rtl/npc_fetch_unit.sv
module npc_fetch_unit #(
    parameter int              XLEN       = 32,
    parameter int              IDX_BITS   = 10,
    parameter int              INST_BYTES = 4,
    parameter logic [XLEN-1:0] START_PC   = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall_i,
    input  logic            res_bubble_i,
    input  logic [XLEN-1:0] res_pc_i,
    input  logic [XLEN-1:0] res_pred_i,
    input  logic            res_br_taken_i,
    input  logic [XLEN-1:0] res_br_target_i,
    input  logic            res_is_jump_i,
    input  logic [XLEN-1:0] res_jump_target_i,
    input  logic            ret_valid_i,
    input  logic [XLEN-1:0] ret_pc_i,
    input  logic [XLEN-1:0] ret_next_i,
    output logic [XLEN-1:0] fetch_pc_o,
    output logic [XLEN-1:0] pred_next_o,
    output logic            mispredict_o
);
    logic [XLEN-1:0] good_next;
    logic            wrong;

    npc_table #(
        .XLEN       (XLEN),
        .IDX_BITS   (IDX_BITS),
        .INST_BYTES (INST_BYTES)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .rd_pc   (fetch_pc_o),
        .rd_next (pred_next_o),
        .wr_en   (ret_valid_i),
        .wr_pc   (ret_pc_i),
        .wr_next (ret_next_i)
    );

    npc_resolve #(
        .XLEN       (XLEN),
        .INST_BYTES (INST_BYTES)
    ) u_resolve (
        .bubble       (res_bubble_i),
        .pc           (res_pc_i),
        .carried_pred (res_pred_i),
        .br_taken     (res_br_taken_i),
        .br_target    (res_br_target_i),
        .is_jump      (res_is_jump_i),
        .jump_target  (res_jump_target_i),
        .good_next    (good_next),
        .wrong        (wrong)
    );

    npc_pc_reg #(
        .XLEN     (XLEN),
        .START_PC (START_PC)
    ) u_pc (
        .clk         (clk),
        .rst         (rst),
        .stall       (stall_i),
        .redirect    (wrong),
        .redirect_pc (good_next),
        .predict_pc  (pred_next_o),
        .pc_q        (fetch_pc_o)
    );

    assign mispredict_o = wrong;

endmodule

// File: rtl/npc_fetch_chk.sv
module npc_fetch_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            stall_i,
    input logic            res_bubble_i,
    input logic [XLEN-1:0] res_pc_i,
    input logic [XLEN-1:0] res_pred_i,
    input logic            res_br_taken_i,
    input logic [XLEN-1:0] res_br_target_i,
    input logic            res_is_jump_i,
    input logic [XLEN-1:0] res_jump_target_i,
    input logic            ret_valid_i,
    input logic [XLEN-1:0] ret_pc_i,
    input logic [XLEN-1:0] ret_next_i,
    input logic [XLEN-1:0] fetch_pc_o,
    input logic [XLEN-1:0] pred_next_o,
    input logic            mispredict_o
);
    // R6
    hold_when_stalled_chk: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !mispredict_o) |=> $stable(fetch_pc_o));

    // R6
    follow_prediction_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !mispredict_o) |=> (fetch_pc_o == $past(pred_next_o)));

    // R6
    redirect_departs_chk: assert property (@(posedge clk) disable iff (rst)
        mispredict_o |=> (fetch_pc_o != $past(res_pred_i)));

    // R5
    bubble_never_flags_chk: assert property (@(posedge clk) disable iff (rst)
        res_bubble_i |-> !mispredict_o);

    // R4
    fallthrough_match_chk: assert property (@(posedge clk) disable iff (rst)
        (!res_bubble_i && !res_br_taken_i && !res_is_jump_i
         && (res_pred_i == res_pc_i + XLEN'(4))) |-> !mispredict_o);

    // R4
    taken_match_chk: assert property (@(posedge clk) disable iff (rst)
        (!res_bubble_i && res_br_taken_i && (res_pred_i == res_br_target_i))
        |-> !mispredict_o);

    logic unused_chk;
    assign unused_chk = ^{res_jump_target_i, ret_valid_i, ret_pc_i, ret_next_i};

endmodule

bind npc_fetch_unit npc_fetch_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/npc_fetch_unit_bench.sv
`timescale 1ns/1ps
module npc_fetch_unit_bench;
    localparam logic [31:0] START = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall_i = 1'b0;
    logic        res_bubble_i = 1'b1;
    logic [31:0] res_pc_i = '0, res_pred_i = '0, res_br_target_i = '0, res_jump_target_i = '0;
    logic        res_br_taken_i = 1'b0, res_is_jump_i = 1'b0;
    logic        ret_valid_i = 1'b0;
    logic [31:0] ret_pc_i = '0, ret_next_i = '0;
    logic [31:0] fetch_pc_o, pred_next_o;
    logic        mispredict_o;

    npc_fetch_unit u_npc_fetch_unit (.*);

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_pc;
    logic [31:0] m_tbl [1024];
    bit          m_vld [1024];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] f_pred(input logic [31:0] pc);
        return m_vld[pc[11:2]] ? m_tbl[pc[11:2]] : pc + 32'd4;
    endfunction

    function automatic logic [31:0] f_good();
        if (res_br_taken_i) return res_br_target_i;
        if (res_is_jump_i) return res_jump_target_i;
        return res_pc_i + 32'd4;
    endfunction

    function automatic logic [31:0] rand_pc();
        logic [31:0] a;
        a = 32'h0000_1000 + 32'(($urandom % 48) * 4);
        if ($urandom % 4 == 0) a = a + 32'h0000_1000;
        return a;
    endfunction

    // Inputs already driven; check outputs, then advance the model across one edge
    task automatic run_cycle(input string ctx);
        logic [31:0] ep, eg;
        bit em;
        #1;
        ep = f_pred(m_pc);
        eg = f_good();
        em = !res_bubble_i && (eg != res_pred_i);
        check(fetch_pc_o == m_pc, {"R6 fetch pc ", ctx}, fetch_pc_o, m_pc);
        check(pred_next_o == ep, {"R3 prediction ", ctx}, pred_next_o, ep);
        check(mispredict_o == em, {"R5 mispredict ", ctx}, 32'(mispredict_o), 32'(em));
        @(posedge clk);
        if (ret_valid_i) begin
            m_tbl[ret_pc_i[11:2]] = ret_next_i;
            m_vld[ret_pc_i[11:2]] = 1'b1;
        end
        if (rst) begin
            m_pc = START;
            foreach (m_vld[i]) m_vld[i] = 1'b0;
        end else if (em) m_pc = eg;
        else if (!stall_i) m_pc = ep;
        @(negedge clk);
    endtask

    task automatic idle();
        rst = 1'b0; stall_i = 1'b0; res_bubble_i = 1'b1;
        res_br_taken_i = 1'b0; res_is_jump_i = 1'b0; ret_valid_i = 1'b0;
    endtask

    task automatic redirect_to(input logic [31:0] tgt);
        idle();
        res_bubble_i = 1'b0; res_pc_i = tgt - 32'd4; res_pred_i = 32'hFFFF_FFF0;
        run_cycle("redirect");
        idle();
    endtask

    task automatic retire(input logic [31:0] pc, input logic [31:0] nxt);
        idle();
        ret_valid_i = 1'b1; ret_pc_i = pc; ret_next_i = nxt; stall_i = 1'b1;
        run_cycle("retire");
        idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        foreach (m_vld[i]) m_vld[i] = 1'b0;
        m_pc = START;
        repeat (2) @(posedge clk);
        @(negedge clk);
        idle();
        // R1 reset state, R2 empty-table default
        check(fetch_pc_o == START, "R1 start address", fetch_pc_o, START);
        check(pred_next_o == START + 32'd4, "R2 invalid entry gives pc+4", pred_next_o, START + 32'd4);

        // Sequential fetch with no resolve activity
        repeat (6) run_cycle("sequential");
        check(fetch_pc_o == START + 32'd24, "R2 sequential walk", fetch_pc_o, START + 32'd24);

        // R4 branch beats jump
        idle();
        res_bubble_i = 1'b0; res_pc_i = 32'h1040; res_br_taken_i = 1'b1; res_br_target_i = 32'h1300;
        res_is_jump_i = 1'b1; res_jump_target_i = 32'h1500; res_pred_i = 32'h1500;
        run_cycle("branch over jump");
        check(fetch_pc_o == 32'h1300, "R4 branch target wins", fetch_pc_o, 32'h1300);
        // R4 jump beats fall-through
        idle();
        res_bubble_i = 1'b0; res_pc_i = 32'h1040; res_is_jump_i = 1'b1; res_jump_target_i = 32'h1500;
        res_pred_i = 32'h1044;
        run_cycle("jump over fallthrough");
        check(fetch_pc_o == 32'h1500, "R4 jump target wins", fetch_pc_o, 32'h1500);
        // R5 match gives no flag; bubble masks a mismatch
        idle();
        res_bubble_i = 1'b0; res_pc_i = 32'h1080; res_pred_i = 32'h1084;
        run_cycle("correct fallthrough");
        idle();
        res_pc_i = 32'h1080; res_pred_i = 32'h2000;
        run_cycle("bubble mismatch");
        // R6 redirect wins over stall
        idle();
        stall_i = 1'b1; res_bubble_i = 1'b0; res_pc_i = 32'h1100; res_pred_i = 32'h0;
        run_cycle("stall plus redirect");
        check(fetch_pc_o == 32'h1104, "R6 redirect beats stall", fetch_pc_o, 32'h1104);
        idle(); stall_i = 1'b1;
        run_cycle("stall hold");
        check(fetch_pc_o == 32'h1104, "R6 stall holds pc", fetch_pc_o, 32'h1104);

        // R7 train, R3 hit and alias
        retire(32'h1200, 32'h1800);
        redirect_to(32'h1200);
        check(pred_next_o == 32'h1800, "R3 trained entry hit", pred_next_o, 32'h1800);
        redirect_to(32'h2200);
        check(pred_next_o == 32'h1800, "R3 tagless alias", pred_next_o, 32'h1800);
        retire(32'h1200, 32'h1204);
        check(pred_next_o == 32'h1204, "R7 retrain to fall-through", pred_next_o, 32'h1204);

        // R8 same-entry write during stalled lookup
        idle(); stall_i = 1'b1; ret_valid_i = 1'b1; ret_pc_i = 32'h1200; ret_next_i = 32'h1A00;
        #1;
        check(pred_next_o == 32'h1204, "R8 old contents same cycle", pred_next_o, 32'h1204);
        run_cycle("same entry write");
        idle(); stall_i = 1'b1;
        #1;
        check(pred_next_o == 32'h1A00, "R8 new contents next cycle", pred_next_o, 32'h1A00);
        run_cycle("after write");

        // R1 reset clears trained entries
        retire(START, 32'h1700);
        idle(); rst = 1'b1;
        run_cycle("reset");
        idle();
        #1;
        check(fetch_pc_o == START, "R1 pc after reset", fetch_pc_o, START);
        check(pred_next_o == START + 32'd4, "R1 table cleared", pred_next_o, START + 32'd4);

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            idle();
            stall_i = ($urandom % 4 == 0);
            res_bubble_i = ($urandom % 3 == 0);
            res_pc_i = rand_pc();
            res_br_taken_i = ($urandom % 4 == 0);
            res_br_target_i = rand_pc();
            res_is_jump_i = ($urandom % 5 == 0);
            res_jump_target_i = rand_pc();
            res_pred_i = ($urandom % 2 == 0) ? f_good() : rand_pc();
            ret_valid_i = ($urandom % 2 == 0);
            ret_pc_i = rand_pc();
            ret_next_i = ($urandom % 3 == 0) ? ret_pc_i + 32'd4 : rand_pc();
            rst = (n % 997 == 996);
            run_cycle("random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule